// File: doc/BRIEF.md
# Pipeline Configuration Version Controller

This block sits at the entry of a multi-table packet-processing pipeline and owns the global configuration version. Every packet header that enters the pipeline passes through it. On the way through, the block writes the current version into the low bits of the packet's metadata word. The tables further down compare that stamped version with their own. When the two differ, a table swaps its active and shadow memories before it processes the packet.

Software loads each table's shadow memory and closes each table's update. Each table then reports itself as primed. Software next pulses a request to advance the version. The block advances only when every table is primed and no earlier advance is still outstanding. It answers every request with a one-cycle accept or refuse pulse.

After an accepted advance, an idle timer runs while all tables stay primed and no packet has entered. If the timer reaches the programmed length, the block sends a forced-commit sweep to the tables. The sweep is a one-hot pulse that visits the tables in pipeline order, one table per cycle.

The packet path is a valid/ready stream with no storage. `out_valid` follows `in_valid` and `in_ready` follows `out_ready` in the same cycle, so back-pressure from downstream reaches the source without delay. A transfer happens on any cycle in which valid and ready are both high. Metadata must stay stable while valid is high and ready is low.

Top module: `pipe_version_ctrl`

## Requirements
- R1: After reset, `cur_version` is 0, `inc_ack`, `inc_nak` and `force_commit` are all 0.
- R2: `out_meta` equals `in_meta` with bits [VER_W-1:0] replaced by `cur_version`; all higher bits pass unchanged in the same cycle.
- R3: `out_valid` equals `in_valid` and `in_ready` equals `out_ready` combinationally; the block holds no packet.
- R4: A request (`inc_req` high for one cycle) while every bit of `table_primed` is 1 and no advance is outstanding increments `cur_version` by one at the next clock edge, and `inc_ack` is high for exactly the following cycle.
- R5: A request while any `table_primed` bit is 0 leaves `cur_version` unchanged and gives a one-cycle `inc_nak` in the following cycle.
- R6: An advance stays outstanding until every table has either shown `table_primed` low or received its forced-commit pulse. A request in that window is refused with `inc_nak`, so the version never runs more than one ahead of any table.
- R7: The version is VER_W bits wide and wraps from its maximum value to 0 on an accepted advance.
- R8: If no packet transfers and all tables stay primed, then `force_commit[0]` rises exactly `timeout_len`+2 cycles after the cycle in which `inc_ack` is high.
- R9: The forced sweep is one-hot. It drives `force_commit[i]` for one cycle each, for i = 0 up to NUM_TABLES-1 in consecutive cycles, and then returns to 0.
- R10: A packet transfer in the `inc_ack` cycle or later, before the timer expires, cancels the forced sweep for that advance.
- R11: Any table showing `table_primed` low before expiry stops the timer for that advance, so no sweep follows.
- R12: After a forced sweep ends, the advance is no longer outstanding, and a new request with all tables primed is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Packet metadata valid from upstream |
| in_ready | output | 1 | Ready toward upstream (equals `out_ready`) |
| in_meta | input | META_W | Incoming packet metadata |
| out_valid | output | 1 | Stamped metadata valid toward the first table |
| out_ready | input | 1 | Ready from the first table |
| out_meta | output | META_W | Metadata with version in bits [VER_W-1:0] |
| table_primed | input | NUM_TABLES | Per-table update-complete status, bit i = table i |
| inc_req | input | 1 | Single-cycle request to advance the version |
| inc_ack | output | 1 | One-cycle pulse: advance accepted |
| inc_nak | output | 1 | One-cycle pulse: advance refused |
| timeout_len | input | TIMER_W | Idle timer length in cycles |
| force_commit | output | NUM_TABLES | One-hot forced-commit sweep, bit i = table i |
| cur_version | output | VER_W | Current pipeline version |

## Verification
The bench targets three cases in particular:
- A second request that arrives while an advance is still outstanding. A design that checks only the primed bits would accept it, and the version would then be two ahead of the tables.
- The exact cycle and order of the forced sweep. A counter that is off by one, or a sweep that runs in reverse, shows up as a pulse in the wrong cycle or on the wrong table.
- The two conditions that cancel the timer: a packet in the acknowledge cycle, and a table that drops primed for one cycle. Ignoring either one produces an unwanted sweep.

Wrap from 255 to 0 is checked on both the version output and the stamped metadata. A design that saturates, or that compares versions by magnitude, fails there.

// File: rtl/pvc_pkg.sv
package pvc_pkg;

  typedef enum logic {
    SWEEP_IDLE = 1'b0,
    SWEEP_RUN  = 1'b1
  } sweep_state_t;

  function automatic logic [7:0] pvc_clog2_min1(input int unsigned n);
    int unsigned w;
    w = 0;
    while ((1 << w) < n) w++;
    if (w == 0) w = 1;
    return 8'(w);
  endfunction

endpackage

// File: rtl/pvc_stamp.sv
module pvc_stamp #(
  parameter int META_W = 32,
  parameter int VER_W  = 8
) (
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [META_W-1:0] in_meta,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [META_W-1:0] out_meta,
  input  logic [VER_W-1:0]  version
);

  localparam int HI_W = META_W - VER_W;

  logic [HI_W-1:0] upper_bits;

  always_comb begin
    upper_bits = in_meta[META_W-1:VER_W];
    out_meta   = {upper_bits, version};
    out_valid  = in_valid;
    in_ready   = out_ready;
  end

endmodule

// File: rtl/pvc_version_gate.sv
module pvc_version_gate #(
  parameter int NUM_TABLES = 4,
  parameter int VER_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inc_req,
  input  logic [NUM_TABLES-1:0] table_primed,
  input  logic [NUM_TABLES-1:0] force_commit,
  output logic [VER_W-1:0]      version,
  output logic                  pending,
  output logic                  inc_ack,
  output logic                  inc_nak
);

  logic                  all_primed;
  logic                  accept;
  logic [NUM_TABLES-1:0] committed;
  logic [NUM_TABLES-1:0] seen_now;

  always_comb begin
    all_primed = &table_primed;
    accept     = inc_req && all_primed && !pending;
    seen_now   = committed | ~table_primed | force_commit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      version   <= '0;
      pending   <= 1'b0;
      committed <= '0;
      inc_ack   <= 1'b0;
      inc_nak   <= 1'b0;
    end else begin
      inc_ack <= accept;
      inc_nak <= inc_req && !accept;
      if (accept) begin
        version   <= version + VER_W'(1);
        pending   <= 1'b1;
        committed <= '0;
      end else if (pending) begin
        committed <= seen_now;
        if (&seen_now) pending <= 1'b0;
      end
    end
  end

  assert_ack_needs_primed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ack |-> $past(&table_primed));

  assert_no_double_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ack |-> !$past(pending));

  assert_one_answer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    inc_req |=> (inc_ack != inc_nak));

  assert_ver_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    inc_ack |-> (version == $past(version) + VER_W'(1)));

endmodule

// File: rtl/pvc_idle_sweep.sv
module pvc_idle_sweep
  import pvc_pkg::*;
#(
  parameter int NUM_TABLES = 4,
  parameter int TIMER_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inc_ack,
  input  logic                  pending,
  input  logic                  pkt_fire,
  input  logic [NUM_TABLES-1:0] table_primed,
  input  logic [TIMER_W-1:0]    timeout_len,
  output logic [NUM_TABLES-1:0] force_commit
);

  localparam int IDX_W = pvc_clog2_min1(NUM_TABLES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_TABLES - 1);

  logic [TIMER_W-1:0] cnt;
  logic               stopped;
  logic               fired;
  logic               all_primed;
  logic               expire;
  sweep_state_t       sweep_st;
  logic [IDX_W-1:0]   idx;

  always_comb begin
    all_primed = &table_primed;
    expire     = pending && !stopped && !fired && !inc_ack
                 && !pkt_fire && all_primed && (cnt == timeout_len);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      stopped <= 1'b1;
      fired   <= 1'b0;
    end else if (inc_ack) begin
      cnt     <= '0;
      stopped <= pkt_fire || !all_primed;
      fired   <= 1'b0;
    end else if (pending && !stopped && !fired) begin
      if (pkt_fire || !all_primed) stopped <= 1'b1;
      else if (expire)             fired   <= 1'b1;
      else                         cnt     <= cnt + TIMER_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sweep_st <= SWEEP_IDLE;
      idx      <= '0;
    end else begin
      case (sweep_st)
        SWEEP_IDLE: if (expire) begin
          sweep_st <= SWEEP_RUN;
          idx      <= '0;
        end
        SWEEP_RUN: begin
          if (idx == LAST_IDX) sweep_st <= SWEEP_IDLE;
          else                 idx      <= idx + IDX_W'(1);
        end
        default: sweep_st <= SWEEP_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_TABLES; g++) begin : g_force
    assign force_commit[g] = (sweep_st == SWEEP_RUN) && (idx == IDX_W'(g));
  end

  assert_force_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(force_commit));

  assert_force_only_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_commit != '0) |-> pending);

  assert_sweep_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (force_commit[0] && NUM_TABLES > 1) |=> (force_commit != '0));

endmodule

// File: rtl/pipe_version_ctrl.sv
module pipe_version_ctrl #(
  parameter int NUM_TABLES = 4,
  parameter int VER_W      = 8,
  parameter int META_W     = 32,
  parameter int TIMER_W    = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [META_W-1:0]     in_meta,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [META_W-1:0]     out_meta,
  input  logic [NUM_TABLES-1:0] table_primed,
  input  logic                  inc_req,
  output logic                  inc_ack,
  output logic                  inc_nak,
  input  logic [TIMER_W-1:0]    timeout_len,
  output logic [NUM_TABLES-1:0] force_commit,
  output logic [VER_W-1:0]      cur_version
);

  logic [VER_W-1:0] version;
  logic             pending;
  logic             pkt_fire;

  assign pkt_fire    = in_valid && in_ready;
  assign cur_version = version;

  pvc_stamp #(.META_W(META_W), .VER_W(VER_W)) u_stamp (
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_meta  (in_meta),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_meta (out_meta),
    .version  (version)
  );

  pvc_version_gate #(.NUM_TABLES(NUM_TABLES), .VER_W(VER_W)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_req     (inc_req),
    .table_primed(table_primed),
    .force_commit(force_commit),
    .version     (version),
    .pending     (pending),
    .inc_ack     (inc_ack),
    .inc_nak     (inc_nak)
  );

  pvc_idle_sweep #(.NUM_TABLES(NUM_TABLES), .TIMER_W(TIMER_W)) u_sweep (
    .clk         (clk),
    .rst_n       (rst_n),
    .inc_ack     (inc_ack),
    .pending     (pending),
    .pkt_fire    (pkt_fire),
    .table_primed(table_primed),
    .timeout_len (timeout_len),
    .force_commit(force_commit)
  );

  assert_stamp_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_meta[VER_W-1:0] == cur_version);

  assert_version_moves_on_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_version != $past(cur_version)) |-> inc_ack);

  assert_stream_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid == in_valid) && (in_ready == out_ready));

endmodule

// File: tb/tb_pipe_version_ctrl.sv
module tb_pipe_version_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int VW = 8;
  localparam int MW = 32;
  localparam int TW = 16;
  localparam int TMO = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [MW-1:0] in_meta, out_meta;
  logic [NT-1:0] table_primed, force_commit;
  logic inc_req, inc_ack, inc_nak;
  logic [TW-1:0] timeout_len;
  logic [VW-1:0] cur_version;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pipe_version_ctrl #(.NUM_TABLES(NT), .VER_W(VW), .META_W(MW), .TIMER_W(TW)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_meta(in_meta),
    .out_valid(out_valid), .out_ready(out_ready), .out_meta(out_meta),
    .table_primed(table_primed), .inc_req(inc_req), .inc_ack(inc_ack),
    .inc_nak(inc_nak), .timeout_len(timeout_len),
    .force_commit(force_commit), .cur_version(cur_version)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Request in one cycle; returns at the negedge of the answer cycle.
  task automatic request();
    @(negedge clk); inc_req = 1'b1;
    @(negedge clk); inc_req = 1'b0;
  endtask

  // Every table shows not-primed for one cycle, then primed again.
  task automatic settle();
    @(negedge clk); table_primed = '0;
    @(negedge clk); table_primed = '1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 version", 64'(cur_version), 64'd0);
    check("R1 ack/nak", 64'({inc_ack, inc_nak}), 64'd0);
    check("R1 force", 64'(force_commit), 64'd0);
  endtask

  task automatic t_stream();
    logic [MW-1:0] pats [4] = '{32'hDEADBEEF, 32'h00000000, 32'hFFFFFFFF, 32'h12345678};
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      in_meta = pats[i]; in_valid = i[0]; out_ready = i[1];
      #1;
      check("R2 stamp", 64'(out_meta), 64'({pats[i][MW-1:VW], cur_version}));
      check("R3 valid", 64'(out_valid), 64'(i[0]));
      check("R3 ready", 64'(in_ready), 64'(i[1]));
    end
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b0;
  endtask

  task automatic t_refuse_unprimed();
    table_primed = 4'b1011;
    request();
    check("R5 nak", 64'({inc_ack, inc_nak}), 64'b01);
    check("R5 version", 64'(cur_version), 64'd0);
    table_primed = '1;
  endtask

  task automatic t_accept_and_hold();
    request();
    check("R4 ack", 64'({inc_ack, inc_nak}), 64'b10);
    check("R4 version", 64'(cur_version), 64'd1);
    @(negedge clk);
    check("R4 ack one cycle", 64'(inc_ack), 64'd0);
    request();
    check("R6 refuse while outstanding", 64'({inc_ack, inc_nak}), 64'b01);
    check("R6 version held", 64'(cur_version), 64'd1);
    settle();
    request();
    check("R6 accept after tables commit", 64'({inc_ack, inc_nak}), 64'b10);
    check("R6 version", 64'(cur_version), 64'd2);
    settle();
  endtask

  task automatic t_packet_cancels();
    request();
    check("R10 ack", 64'(inc_ack), 64'd1);
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b0;
    for (int j = 0; j < TMO + NT + 6; j++) begin
      if (force_commit !== '0) check("R10 no sweep after packet", 64'(force_commit), 64'd0);
      @(negedge clk);
    end
    check("R10 no sweep after packet", 64'(force_commit), 64'd0);
    settle();
  endtask

  task automatic t_timeout_sweep();
    logic [VW-1:0] v;
    request();
    check("R8 ack", 64'(inc_ack), 64'd1);
    v = cur_version;
    for (int j = 1; j <= TMO + 1; j++) begin
      @(negedge clk);
      if (force_commit !== '0) check("R8 early force", 64'(force_commit), 64'd0);
    end
    for (int i = 0; i < NT; i++) begin
      @(negedge clk);
      check("R9 sweep order", 64'(force_commit), 64'(1) << i);
    end
    @(negedge clk);
    check("R9 sweep ends", 64'(force_commit), 64'd0);
    request();
    check("R12 accept after sweep", 64'({inc_ack, inc_nak}), 64'b10);
    check("R12 version", 64'(cur_version), 64'(v + VW'(1)));
    settle();
  endtask

  task automatic t_unprimed_halts();
    request();
    check("R11 ack", 64'(inc_ack), 64'd1);
    table_primed = 4'b1101;
    @(negedge clk); table_primed = '1;
    for (int j = 0; j < TMO + NT + 6; j++) begin
      if (force_commit !== '0) check("R11 no sweep", 64'(force_commit), 64'd0);
      @(negedge clk);
    end
    check("R11 no sweep", 64'(force_commit), 64'd0);
    request();
    check("R6 still outstanding", 64'({inc_ack, inc_nak}), 64'b01);
    settle();
  endtask

  task automatic t_wrap();
    int guard = 0;
    while (cur_version != 8'hFF && guard < 300) begin
      request();
      settle();
      guard++;
    end
    check("R7 reached max", 64'(cur_version), 64'hFF);
    request();
    check("R7 wrap ack", 64'(inc_ack), 64'd1);
    check("R7 wrap to zero", 64'(cur_version), 64'd0);
    in_meta = 32'hA5A5A5A5;
    #1;
    check("R7 stamped zero", 64'(out_meta), 64'h A5A5A500);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_meta = '0;
    table_primed = '1; inc_req = 1'b0; timeout_len = TW'(TMO);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stream();
    t_refuse_unprimed();
    t_accept_and_hold();
    t_packet_cancels();
    t_timeout_sweep();
    t_unprimed_halts();
    t_wrap();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule